// File: doc/BRIEF.md
# Two-Output Interrupt Router with Masking

This block collects 32 level-sensitive interrupt request lines and turns them into two processor interrupt lines: a fast interrupt (FIQ) and a normal interrupt (IRQ). Each request line arrives already enabled at its peripheral. It is typically the OR of that peripheral's own detailed status conditions. Software sees four 32-bit registers on a small register bus. A mask register lets each line through or blocks it. A class register sends each line that passes to either the fast or the normal path. Two read-only pending views show which lines are live on each path.

The two processor outputs are the OR of the lines pending on their path. They are registered, so they follow a source or control change after one clock. A separate idle input opens a wake path that ignores the mask. While idle is high, any asserted source raises the wake output one clock later, so a sleeping processor can be resumed by a line software has masked. The asynchronous reset is released synchronously inside the block. Mask and class reset to zero, but software is still expected to program them before enabling interrupts in the core.

Top module: `irq_router`

## Requirements
- R1: After reset, the mask and class registers read 0, and fiq_o, irq_o, wake_o and rdata_o are all 0.
- R2: A write (wr_en_i high) at word index 1 (offset 0x4) loads the mask register, and a write at word index 2 (offset 0x8) loads the class register. Each reads back unchanged from the same index.
- R3: Reading word index 0 (offset 0x0) returns the normal-path pending view, src_i AND mask AND NOT class, using the source values present at the read edge. Mask bit 1 means the line passes. Class bit 0 means the normal path.
- R4: Reading word index 3 (offset 0xC) returns the fast-path pending view, src_i AND mask AND class. Class bit 1 means the fast path.
- R5: Writes to word index 0 or 3 have no effect: mask and class keep their values, and both pending views still follow the sources.
- R6: fiq_o equals the OR of the fast-path pending bits, registered: it changes on the first clock edge after the change in a source, the mask or the class register.
- R7: irq_o equals the OR of the normal-path pending bits, registered in the same way.
- R8: wake_o is 1 on the clock after a cycle in which idle_i is high and any source is asserted, whatever the mask. It is 0 after any cycle with idle_i low. idle_i does not alter fiq_o or irq_o.
- R9: rdata_o is loaded only on a clock edge where rd_en_i is high. It appears the cycle after the request and holds while rd_en_i stays low.
- R10: When a read and a write to the same register occur in one cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| idle_i | input | 1 | Processor idle indication; enables the mask-free wake path |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word index: 0 normal pending, 1 mask, 2 class, 3 fast pending |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |
| wake_o | output | 1 | Resume request while idle |

## Verification
The hardest situations to reach from the ports are the ones where three things are set up together. One is a source that the mask blocks from both interrupt outputs but that must still raise the wake output. Another is a read and a write to the same register in one cycle. The stimulus clears the mask entirely, raises idle and walks a single active source over every bit position. It checks that wake rises while both interrupt outputs stay low. For the same-cycle case it asserts both strobes on the mask index with a new value and expects the old value back, then the new value on the next read. Each bit's path through masking and class selection is covered by walking sources across fixed and pseudo-random mask and class patterns.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Word index of each register on the bus (offset = index * 4)
  typedef enum logic [1:0] {
    SEL_NRM_PEND = 2'd0,
    SEL_MASK     = 2'd1,
    SEL_CLASS    = 2'd2,
    SEL_FST_PEND = 2'd3
  } reg_sel_e;

  localparam int unsigned SEL_W = 2;

  function automatic reg_sel_e decode_sel(input logic [SEL_W-1:0] idx);
    return reg_sel_e'(idx);
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] class_q
);

  logic mask_en;
  logic class_en;

  // Only the two writable registers have enables; pending views ignore writes
  always_comb begin
    mask_en  = wr_en && (sel == SEL_MASK);
    class_en = wr_en && (sel == SEL_CLASS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_q <= '0;
    end else if (class_en) begin
      class_q <= wdata;
    end
  end

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] cls,
  input  logic               idle,
  output logic [NUM_SRC-1:0] nrm_pend,
  output logic [NUM_SRC-1:0] fst_pend,
  output logic               wake_raw
);

  logic [NUM_SRC-1:0] passed;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      passed[i]   = src[i] & mask[i];
      fst_pend[i] = passed[i] & cls[i];
      nrm_pend[i] = passed[i] & ~cls[i];
    end
  end

  // Wake path bypasses the mask entirely
  always_comb begin
    wake_raw = idle & (|src);
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] nrm_pend,
  input  logic [NUM_SRC-1:0] fst_pend,
  input  logic               wake_raw,
  output logic               fiq_q,
  output logic               irq_q,
  output logic               wake_q
);

  logic fiq_d;
  logic irq_d;
  logic wake_d;

  always_comb begin
    fiq_d  = |fst_pend;
    irq_d  = |nrm_pend;
    wake_d = wake_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_q  <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      fiq_q  <= fiq_d;
      irq_q  <= irq_d;
      wake_q <= wake_d;
    end
  end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] nrm_pend,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] cls,
  input  logic [NUM_SRC-1:0] fst_pend,
  output logic [DATA_W-1:0]  rdata_q
);

  logic [NUM_SRC-1:0] picked;
  logic [DATA_W-1:0]  rdata_d;

  always_comb begin
    unique case (sel)
      SEL_NRM_PEND: picked = nrm_pend;
      SEL_MASK:     picked = mask;
      SEL_CLASS:    picked = cls;
      SEL_FST_PEND: picked = fst_pend;
      default:      picked = '0;
    endcase
    rdata_d              = '0;
    rdata_d[NUM_SRC-1:0] = picked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic              idle_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fiq_o,
  output logic              irq_o,
  output logic              wake_o
);

  logic               rst_sync_n;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] class_q;
  logic [NUM_SRC-1:0] nrm_pend;
  logic [NUM_SRC-1:0] fst_pend;
  logic               wake_raw;

  always_comb begin
    sel = decode_sel(addr_i);
  end

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en_i),
    .sel     (sel),
    .wdata   (wdata_i[NUM_SRC-1:0]),
    .mask_q  (mask_q),
    .class_q (class_q)
  );

  irq_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
    .src      (src_i),
    .mask     (mask_q),
    .cls      (class_q),
    .idle     (idle_i),
    .nrm_pend (nrm_pend),
    .fst_pend (fst_pend),
    .wake_raw (wake_raw)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .nrm_pend (nrm_pend),
    .fst_pend (fst_pend),
    .wake_raw (wake_raw),
    .fiq_q    (fiq_o),
    .irq_q    (irq_o),
    .wake_q   (wake_o)
  );

  irq_read_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en_i),
    .sel      (sel),
    .nrm_pend (nrm_pend),
    .mask     (mask_q),
    .cls      (class_q),
    .fst_pend (fst_pend),
    .rdata_q  (rdata_o)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic [NUM_SRC-1:0] src,
  input logic               idle,
  input logic               wr_en,
  input logic               rd_en,
  input logic [1:0]         addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               fiq,
  input logic               irq,
  input logic               wake
);

  logic               armed;
  logic [NUM_SRC-1:0] sh_mask;
  logic [NUM_SRC-1:0] sh_cls;
  logic [DATA_W-1:0]  exp_mask_w;
  logic [DATA_W-1:0]  exp_cls_w;
  logic [DATA_W-1:0]  exp_nrm_w;
  logic [DATA_W-1:0]  exp_fst_w;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      armed   <= 1'b0;
      sh_mask <= '0;
      sh_cls  <= '0;
    end else begin
      armed <= 1'b1;
      if (wr_en && addr == 2'd1) sh_mask <= wdata[NUM_SRC-1:0];
      if (wr_en && addr == 2'd2) sh_cls  <= wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    exp_mask_w = '0; exp_mask_w[NUM_SRC-1:0] = sh_mask;
    exp_cls_w  = '0; exp_cls_w[NUM_SRC-1:0]  = sh_cls;
    exp_nrm_w  = '0; exp_nrm_w[NUM_SRC-1:0]  = src & sh_mask & ~sh_cls;
    exp_fst_w  = '0; exp_fst_w[NUM_SRC-1:0]  = src & sh_mask & sh_cls;
  end

  assert_mask_rd_R2: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (rd_en && addr == 2'd1) |=> (rdata == $past(exp_mask_w)));

  assert_class_rd_R2: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (rd_en && addr == 2'd2) |=> (rdata == $past(exp_cls_w)));

  assert_nrm_pend_R3: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (rd_en && addr == 2'd0) |=> (rdata == $past(exp_nrm_w)));

  assert_fst_pend_R4: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (rd_en && addr == 2'd3) |=> (rdata == $past(exp_fst_w)));

  assert_fiq_out_R6: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    fiq == $past(|exp_fst_w));

  assert_irq_out_R7: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    irq == $past(|exp_nrm_w));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    wake == $past(idle && (|src)));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    !rd_en |=> $stable(rdata));

endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n_s (rst_sync_n),
  .src     (src_i),
  .idle    (idle_i),
  .wr_en   (wr_en_i),
  .rd_en   (rd_en_i),
  .addr    (addr_i),
  .wdata   (wdata_i),
  .rdata   (rdata_o),
  .fiq     (fiq_o),
  .irq     (irq_o),
  .wake    (wake_o)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        idle;
  logic        wr_en;
  logic        rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        fiq;
  logic        irq;
  logic        wake;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_router u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src),
    .idle_i  (idle),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .fiq_o   (fiq),
    .irq_o   (irq),
    .wake_o  (wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] lfsr(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  // Full check of pending views and outputs for one configuration
  task automatic check_cfg(input logic [31:0] m, input logic [31:0] c, input logic [31:0] s);
    logic [31:0] d;
    logic [31:0] en;
    logic [31:0] ef;
    en = s & m & ~c;
    ef = s & m & c;
    src = s; idle = 1'b0;
    step();
    chk("R6 fiq_o", {31'd0, fiq}, {31'd0, |ef});
    chk("R7 irq_o", {31'd0, irq}, {31'd0, |en});
    bus_rd(2'd0, d); chk("R3 normal pending", d, en);
    bus_rd(2'd3, d); chk("R4 fast pending", d, ef);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m;
    logic [31:0] c;
    logic [31:0] r;
    rst_n = 1'b0; src = '1; idle = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 fiq_o", {31'd0, fiq}, 32'd0);
    chk("R1 irq_o", {31'd0, irq}, 32'd0);
    chk("R1 wake_o", {31'd0, wake}, 32'd0);
    chk("R1 rdata_o", rdata, 32'd0);
    bus_rd(2'd1, d); chk("R1 mask", d, 32'd0);
    bus_rd(2'd2, d); chk("R1 class", d, 32'd0);

    // R2: write / read-back sweep
    for (int k = 0; k < 32; k++) begin
      bus_wr(2'd1, 32'd1 << k);
      bus_wr(2'd2, ~(32'd1 << k));
      bus_rd(2'd1, d); chk("R2 mask readback", d, 32'd1 << k);
      bus_rd(2'd2, d); chk("R2 class readback", d, ~(32'd1 << k));
    end

    // R3 R4 R6 R7: walking source over fixed patterns
    m = 32'hA5A5_F00F; c = 32'h0FF0_3C3C;
    bus_wr(2'd1, m); bus_wr(2'd2, c);
    for (int b = 0; b < 32; b++) check_cfg(m, c, 32'd1 << b);
    check_cfg(m, c, 32'h0);
    check_cfg(m, c, 32'hFFFF_FFFF);

    // Pseudo-random configurations
    r = 32'h1234_5679;
    for (int i = 0; i < 40; i++) begin
      r = lfsr(lfsr(r)); m = r;
      r = lfsr(lfsr(r)); c = r;
      r = lfsr(lfsr(r));
      bus_wr(2'd1, m); bus_wr(2'd2, c);
      check_cfg(m, c, r);
    end

    // R5: writes to pending indices are ignored
    m = 32'h00FF_00FF; c = 32'h0F0F_0F0F;
    bus_wr(2'd1, m); bus_wr(2'd2, c);
    src = 32'h3333_CCCC;
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_wr(2'd3, 32'h0000_0000);
    bus_rd(2'd1, d); chk("R5 mask unchanged", d, m);
    bus_rd(2'd2, d); chk("R5 class unchanged", d, c);
    bus_rd(2'd0, d); chk("R5 normal pending follows src", d, 32'h3333_CCCC & m & ~c);
    bus_rd(2'd3, d); chk("R5 fast pending follows src", d, 32'h3333_CCCC & m & c);

    // R6 R7: one-clock latency, output must not change before the edge
    bus_wr(2'd1, 32'h0000_0003); bus_wr(2'd2, 32'h0000_0001);
    src = 32'h0; step();
    src = 32'h1; #1;
    chk("R6 fiq_o before edge", {31'd0, fiq}, 32'd0);
    step();
    chk("R6 fiq_o after edge", {31'd0, fiq}, 32'd1);
    chk("R7 irq_o stays low", {31'd0, irq}, 32'd0);
    src = 32'h2; #1;
    chk("R7 irq_o before edge", {31'd0, irq}, 32'd0);
    step();
    chk("R7 irq_o after edge", {31'd0, irq}, 32'd1);
    chk("R6 fiq_o drops", {31'd0, fiq}, 32'd0);

    // R8: wake path ignores mask
    bus_wr(2'd1, 32'h0);
    idle = 1'b1;
    for (int b = 0; b < 32; b++) begin
      src = 32'd1 << b;
      step();
      chk("R8 wake with masked source", {31'd0, wake}, 32'd1);
      chk("R8 fiq_o stays low in idle", {31'd0, fiq}, 32'd0);
      chk("R8 irq_o stays low in idle", {31'd0, irq}, 32'd0);
    end
    src = 32'h0; step();
    chk("R8 wake no source", {31'd0, wake}, 32'd0);
    idle = 1'b0; src = 32'hFFFF_FFFF; step();
    chk("R8 wake not idle", {31'd0, wake}, 32'd0);

    // R9: read data holds without a read strobe
    bus_wr(2'd1, 32'hDEAD_BEEF);
    bus_rd(2'd1, d); chk("R9 read value", d, 32'hDEAD_BEEF);
    bus_wr(2'd1, 32'h1111_2222);
    src = 32'h5555_AAAA; step(); step();
    chk("R9 rdata held", rdata, 32'hDEAD_BEEF);

    // R10: simultaneous read and write of the same register
    wr_en = 1'b1; rd_en = 1'b1; addr = 2'd1; wdata = 32'hCAFE_F00D;
    step();
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read returns old value", rdata, 32'h1111_2222);
    bus_rd(2'd1, d); chk("R10 next read returns new", d, 32'hCAFE_F00D);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule